// File: doc/BRIEF.md
# Fixed-Interval Periodic Pulse Generator

This block turns the nominal tick stream of a precision time counter into periodic output pulses, for example a one-pulse-per-second line. Each channel owns a down-counter that is loaded with a programmable interval, in nanoseconds, and reduced by the tick period on every tick. When the count has run out, the channel reloads, raises its pulse line and flags a one-cycle event that can drive an interrupt.

The programmed interval is the wanted period minus one tick period. For example, with a 10 ns tick, a prescale of 100 and 999999990 programmed, the output is 1 Hz. With 99990 programmed instead, the output is 10 kHz. Channel 0 is normally set up for the one-second pulse. The pulse width is not one clock wide. A prescale value that all channels share sets it, and each pulse lasts prescale ticks. Three channels share the tick period and the prescale value. Each channel has its own interval and its own enable.

Top module: `fixed_interval_pulser`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `pulse_o` and `event_o` bit is 0 and every interval counter is cleared.
- R2: An enabled channel's counter drops by `tick_period_i` on each tick and saturates at zero. On the tick where the counter is already zero, the channel reloads from its interval, so reloads are ceil(I/T)+1 ticks apart (I/T+1 when I is a multiple of T).
- R3: On the clock after a reload tick, `pulse_o` of that channel goes high. It stays high until the clock after the tick that follows the reload tick by the prescale value in ticks.
- R4: A prescale value of 0 behaves exactly like a prescale of 1 (a pulse of one tick).
- R5: `event_o` of a channel is high for exactly the one clock after each reload tick, and on that clock the channel's `pulse_o` is high. No event appears after a clock without a tick.
- R6: While a channel's `chan_en_i` bit is 0, its `pulse_o` and `event_o` are 0 from the next clock on, its ticks are ignored, and its counter follows its interval value.
- R7: When a channel is enabled again, its first reload comes a full interval after the enable (ceil(I/T)+1 ticks), whatever state it had when it was disabled.
- R8: A new interval value written while a channel runs does not change the countdown in progress. It is used from the next reload on.
- R9: The channels count independently. They share only `tick_period_i` and `prescale_i`. Channel c takes its interval from `interval_i[c*IVL_W +: IVL_W]`.
- R10: On an enabled channel, `pulse_o` changes only on the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock strobe per nominal tick of the time counter |
| tick_period_i | input | PER_W | Nanoseconds advanced per tick |
| prescale_i | input | PSC_W | Pulse width in ticks, shared by all channels (0 is treated as 1) |
| interval_i | input | NCH*IVL_W | Per-channel interval in nanoseconds, channel c in bits [c*IVL_W +: IVL_W] |
| chan_en_i | input | NCH | Per-channel enable |
| pulse_o | output | NCH | Per-channel pulse line |
| event_o | output | NCH | Per-channel one-clock event flag at each pulse start |

## Verification
The bench goes after the following corner cases.

- **Off-by-one in the period.** A design that reloaded on the tick that reaches zero, rather than the tick after it, would deliver every event one tick early.
- **Intervals that are not a multiple of the tick period.** A counter that wraps instead of saturating at zero would run for billions of ticks.
- **Prescale of zero.** If a zero prescale were passed through, the pulse and its event would never appear.
- **Disabling in the middle of a pulse, then enabling again.** A design that left the pulse high would fail the check, and so would one that resumed the old countdown instead of starting a full interval.
- **Changing the interval while a channel runs.** A design that restarted the countdown at once would shift the next event.
- **Sparse ticks.** A pulse that counted clocks instead of ticks would come out short.

// File: rtl/fip_pkg.sv
// Package fip_pkg
// Shared defaults for the fixed-interval pulse generator.
// Assumes: one channel count limit for the whole generator.
package fip_pkg;
    parameter int unsigned FIP_MAX_CH    = 3;
    parameter int unsigned FIP_DEF_IVL_W = 32;
    parameter int unsigned FIP_DEF_PER_W = 8;
    parameter int unsigned FIP_DEF_PSC_W = 16;
endpackage

// File: rtl/fip_prescale.sv
// Module fip_prescale
// Registers the shared prescale value and maps 0 to 1, so that every
// channel sees a pulse width of at least one tick.
// Assumes: a prescale change may take effect one clock late.
module fip_prescale #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] prescale_i,
    output logic [PSC_W-1:0] psc_o
);
    localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

    logic [PSC_W-1:0] psc_q;

    // Hold the effective prescale: zero is replaced by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= ONE;
        end else begin
            psc_q <= (prescale_i == '0) ? ONE : prescale_i;
        end
    end

    assign psc_o = psc_q;
endmodule

// File: rtl/fip_countdown.sv
// Module fip_countdown
// Per-channel interval counter. It drops by the tick period on each tick,
// saturates at zero and reloads on the tick after reaching zero, and
// reports that tick as a reload.
// Assumes: while disabled, the counter tracks the interval input.
module fip_countdown #(
    parameter int unsigned IVL_W = 32,
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [IVL_W-1:0] interval_i,
    output logic             reload_o
);
    logic [IVL_W-1:0] cnt_q;
    logic [IVL_W-1:0] step;
    logic             at_zero;

    assign step     = IVL_W'(period_i);
    assign at_zero  = (cnt_q == '0);
    assign reload_o = tick_i && en_i && at_zero;

    // Count down on ticks, reload after zero, and follow the interval when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= interval_i;
        end else if (tick_i) begin
            if (at_zero) begin
                cnt_q <= interval_i;
            end else if (cnt_q > step) begin
                cnt_q <= cnt_q - step;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !at_zero && period_i != '0) |=> (cnt_q < $past(cnt_q))); // R2

    AST_NO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |-> !reload_o); // R6
endmodule

// File: rtl/fip_shaper.sv
// Module fip_shaper
// Per-channel pulse shaper. A reload starts a pulse that lasts psc_i ticks
// and raises a one-clock event flag.
// Assumes: psc_i is never zero (fip_prescale guarantees it).
module fip_shaper #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             reload_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             pulse_o,
    output logic             event_o
);
    logic [PSC_W-1:0] wcnt_q;
    logic             evt_q;

    // Load the width counter on reload and drain it one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            evt_q  <= 1'b0;
        end else if (!en_i) begin
            wcnt_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= reload_i;
            if (reload_i) begin
                wcnt_q <= psc_i;
            end else if (tick_i && wcnt_q != '0) begin
                wcnt_q <= wcnt_q - 1'b1;
            end
        end
    end

    assign pulse_o = (wcnt_q != '0);
    assign event_o = evt_q;

    AST_PSC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psc_i != '0); // R4

    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (!pulse_o && !event_o)); // R6

    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i) |=> !event_o); // R5

    AST_EVT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> pulse_o); // R3

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(pulse_o)); // R10
endmodule

// File: rtl/fixed_interval_pulser.sv
// Module fixed_interval_pulser
// Top of the fixed-interval pulse generator. It holds NCH independent
// channels that share the tick period and one prescaler.
// Assumes: tick_i is a one-clock strobe; each interval is given in
// nanoseconds minus one tick period.
module fixed_interval_pulser #(
    parameter int unsigned NCH   = fip_pkg::FIP_MAX_CH,
    parameter int unsigned IVL_W = fip_pkg::FIP_DEF_IVL_W,
    parameter int unsigned PER_W = fip_pkg::FIP_DEF_PER_W,
    parameter int unsigned PSC_W = fip_pkg::FIP_DEF_PSC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [PER_W-1:0]     tick_period_i,
    input  logic [PSC_W-1:0]     prescale_i,
    input  logic [NCH*IVL_W-1:0] interval_i,
    input  logic [NCH-1:0]       chan_en_i,
    output logic [NCH-1:0]       pulse_o,
    output logic [NCH-1:0]       event_o
);
    logic [PSC_W-1:0] psc_eff;
    logic [NCH-1:0]   reload;

    fip_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .prescale_i(prescale_i),
        .psc_o     (psc_eff)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        fip_countdown #(.IVL_W(IVL_W), .PER_W(PER_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .en_i      (chan_en_i[c]),
            .period_i  (tick_period_i),
            .interval_i(interval_i[c*IVL_W +: IVL_W]),
            .reload_o  (reload[c])
        );

        fip_shaper #(.PSC_W(PSC_W)) u_shp (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .en_i    (chan_en_i[c]),
            .reload_i(reload[c]),
            .psc_i   (psc_eff),
            .pulse_o (pulse_o[c]),
            .event_o (event_o[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n) |=> (pulse_o == '0 && event_o == '0)); // R1
endmodule

// File: tb/fixed_interval_pulser_tb_top.sv
module fixed_interval_pulser_tb_top;
    localparam int NCH = 3;
    localparam int IW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_s = 1'b0;
    logic [7:0]      per_s = 8'd10;
    logic [15:0]     psc_s = 16'd4;
    logic [NCH*IW-1:0] ivl_s = '0;
    logic [NCH-1:0]  en_s = '0;
    logic [NCH-1:0]  pulse_o;
    logic [NCH-1:0]  event_o;

    int checks = 0;
    int errors = 0;
    int cap_ticks = 0;
    int cur_t = 10;
    int cur_p = 4;
    int exp_q[NCH][$];
    int rise_t[NCH];
    logic [NCH-1:0] prev_p = '0;
    logic [NCH-1:0] wchk = '1;
    logic [NCH-1:0] en_seen = '0;
    logic tick_seen = 1'b0;
    logic done = 1'b0;
    int e_val;

    always #2 clk = ~clk;

    fixed_interval_pulser dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_s), .tick_period_i(per_s),
        .prescale_i(psc_s), .interval_i(ivl_s), .chan_en_i(en_s),
        .pulse_o(pulse_o), .event_o(event_o)
    );

    // Count captured ticks and note what the last edge sampled.
    always @(posedge clk) begin
        if (rst_n && tick_s) cap_ticks <= cap_ticks + 1;
        tick_seen <= rst_n && tick_s;
        en_seen   <= en_s;
    end

    // Monitor: pop expected event ticks and check width and tick alignment.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (event_o[c]) begin
                    checks++;
                    if (exp_q[c].size() == 0) begin
                        errors++;
                        $display("FAIL R5 ch%0d unexpected event at tick %0d, expected none", c, cap_ticks);
                    end else begin
                        e_val = exp_q[c].pop_front();
                        if (e_val != cap_ticks) begin
                            errors++;
                            $display("FAIL R2 ch%0d event at tick %0d, expected tick %0d", c, cap_ticks, e_val);
                        end
                    end
                end
                if (pulse_o[c] && !prev_p[c]) begin
                    rise_t[c] = cap_ticks;
                    checks++;
                    if (!event_o[c]) begin
                        errors++;
                        $display("FAIL R5 ch%0d pulse rose with event=%0b, expected 1", c, event_o[c]);
                    end
                end
                if (!pulse_o[c] && prev_p[c] && wchk[c]) begin
                    checks++;
                    if (cap_ticks - rise_t[c] != cur_p) begin
                        errors++;
                        $display("FAIL R3 ch%0d pulse width %0d ticks, expected %0d", c, cap_ticks - rise_t[c], cur_p);
                    end
                end
                if (pulse_o[c] != prev_p[c] && en_seen[c]) begin
                    checks++;
                    if (!tick_seen) begin
                        errors++;
                        $display("FAIL R10 ch%0d pulse changed to %0b without a tick, expected %0b", c, pulse_o[c], prev_p[c]);
                    end
                end
                prev_p[c] = pulse_o[c];
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick_s = 1'b1;
            step();
            tick_s = 1'b0;
            repeat (gap) step();
        end
    endtask

    // Driver: program and enable a channel, push the expected event ticks.
    task automatic start_ch(input int c, input int ivl, input int nev, output int e0);
        int pt;
        ivl_s[c*IW +: IW] = IW'(ivl);
        step();
        step();
        en_s[c] = 1'b1;
        e0 = cap_ticks;
        pt = (ivl + cur_t - 1) / cur_t + 1;
        for (int k = 1; k <= nev; k++) exp_q[c].push_back(e0 + k * pt);
    endtask

    task automatic check_drained(input string tag);
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (exp_q[c].size() != 0) begin
                errors++;
                $display("FAIL %s ch%0d %0d events missing, expected 0", tag, c, exp_q[c].size());
                exp_q[c].delete();
            end
        end
    endtask

    task automatic set_cfg(input int t, input int p);
        per_s = 8'(t);
        psc_s = 16'(p);
        cur_t = t;
        cur_p = (p == 0) ? 1 : p;
        step();
        step();
    endtask

    initial begin
        int e0;
        repeat (3) step();
        @(negedge clk);
        checks++;
        if (pulse_o != '0 || event_o != '0) begin
            errors++;
            $display("FAIL R1 outputs pulse=%b event=%b in reset, expected 0", pulse_o, event_o);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pulse_o != '0 || event_o != '0) begin
            errors++;
            $display("FAIL R1 outputs pulse=%b event=%b after reset, expected 0", pulse_o, event_o);
        end
        step();

        // Phase A, R2/R3: ticks every clock, T=10, prescale 4, interval 110.
        set_cfg(10, 4);
        start_ch(0, 110, 3, e0);
        run_ticks(40, 0);
        en_s[0] = 1'b0;
        step();
        check_drained("R2");

        // Phase B, R9: sparse ticks, two channels, prescale 2.
        set_cfg(10, 2);
        start_ch(1, 50, 4, e0);
        start_ch(2, 230, 1, e0);
        run_ticks(26, 2);
        en_s = '0;
        step();
        check_drained("R9");

        // Phase C, R4 (prescale 0) and R2 (interval not a multiple of T).
        set_cfg(5, 0);
        ivl_s[1*IW +: IW] = 32'd27;
        start_ch(0, 25, 3, e0);
        en_s[1] = 1'b1;
        exp_q[1].push_back(e0 + 7);
        exp_q[1].push_back(e0 + 14);
        run_ticks(19, 1);
        en_s = '0;
        step();
        check_drained("R4");

        // Phase D, R6/R7: disable in the middle of a pulse, then enable again.
        set_cfg(10, 4);
        start_ch(0, 110, 1, e0);
        run_ticks(13, 0);
        wchk[0] = 1'b0;
        en_s[0] = 1'b0;
        step();
        @(negedge clk);
        checks++;
        if (pulse_o[0] || event_o[0]) begin
            errors++;
            $display("FAIL R6 ch0 pulse=%0b event=%0b after disable, expected 0", pulse_o[0], event_o[0]);
        end
        run_ticks(30, 0);
        @(negedge clk);
        checks++;
        if (pulse_o[0]) begin
            errors++;
            $display("FAIL R6 ch0 pulse=%0b while disabled with ticks, expected 0", pulse_o[0]);
        end
        step();
        wchk[0] = 1'b1;
        start_ch(0, 110, 1, e0);
        run_ticks(16, 0);
        en_s[0] = 1'b0;
        step();
        check_drained("R7");

        // Phase E, R8: interval changed while running applies at next reload.
        start_ch(0, 110, 1, e0);
        exp_q[0].push_back(e0 + 24);
        exp_q[0].push_back(e0 + 32);
        exp_q[0].push_back(e0 + 40);
        run_ticks(12, 0);
        ivl_s[0 +: IW] = 32'd70;
        run_ticks(32, 0);
        en_s[0] = 1'b0;
        step();
        check_drained("R8");

        repeat (4) step();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, expected the run to end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule